// File: doc/BRIEF.md
# Edge-Kicked Watchdog Timer

This block is a software watchdog with an 8-bit control register. The register is written over a simple parallel write port. It holds a timeout multiplier, a tick-rate select and a steering bit. Once the multiplier is nonzero, a prescaler and a tick counter count toward expiry. Software keeps the watchdog alive in one of two ways: it rewrites the register, or it toggles a kick input. Either edge of the kick input counts. The kick input is asynchronous and passes through a synchronizer before edges are detected.

When the count expires, a sticky timeout flag is set. The steering bit picks what the expiry drives. With the steering bit clear, the flag appears on an interrupt line. With it set, the expiry produces a one-cycle reset pulse. Only a write of all zeros clears a pending timeout, and that write also disables the watchdog. A power-down input disables the watchdog and clears the register and the flag.

Top module: `wdt_edge_top`

## Requirements
- R1: After reset, `cfg_o` is 8'h00 and `timeout_o`, `irq_o` and `rst_pulse_o` are all low.
- R2: The register fields are: bits [6:2] hold the multiplier M, and bits [1:0] hold the rate select S. The tick period is P = TICK_UNIT * 4^S cycles. `timeout_o` rises exactly M*P clock edges after the edge that accepts the write.
- R3: Every accepted write restarts the countdown from zero. This holds even when the value written is the same as the value already in the register.
- R4: A rising or a falling transition of `kick` restarts the countdown. Take the first clock edge after `kick` changes as edge 1. The restart takes effect at edge 3, so expiry follows M*P edges after edge 3.
- R5: Once set, `timeout_o` stays high through nonzero writes and through kick edges. Counting halts while it is high.
- R6: A write of 8'h00 clears `timeout_o` on the next edge and disables counting.
- R7: A write with M = 0 and S nonzero (for example 8'h03) disables counting, the same as 8'h00.
- R8: Bit [7] steers the expiry. When it is 0, `irq_o` follows `timeout_o`. When it is 1, `irq_o` stays low and `rst_pulse_o` is high for exactly the one cycle in which `timeout_o` first goes high.
- R9: While `pwr_down` is high, the register reads 8'h00, `timeout_o` is low and writes are ignored. After `pwr_down` is released, the watchdog stays disabled until it is written again.
- R10: `cfg_o` returns the last accepted write value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_down | input | 1 | Power-down: forces the watchdog disabled and clears the register |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| kick | input | 1 | Asynchronous kick input; either edge restarts the countdown |
| cfg_o | output | 8 | Current register contents |
| timeout_o | output | 1 | Sticky expiry flag |
| irq_o | output | 1 | Expiry routed to the interrupt line (steering bit clear) |
| rst_pulse_o | output | 1 | One-cycle reset pulse on expiry (steering bit set) |

## Verification
The hardest case to reach is a restart that lands close to the expiry edge. The kick has to travel through two synchronizer flops and an edge-compare flop before it restarts the countdown. The bench changes `kick` a few cycles into a short countdown and checks that expiry moves to exactly M*P edges after the third clock edge. It does this for both a rising and a falling kick. The latency of every encoding is checked by a sweep over all four rate selects, several multipliers and both steering values, with a small tick unit.

// File: rtl/wdt_edge_pkg.sv
package wdt_edge_pkg;
    localparam int MULT_W = 5;
    localparam int RES_W  = 2;
    localparam int CFG_W  = 1 + MULT_W + RES_W;

    typedef struct packed {
        logic              steer;
        logic [MULT_W-1:0] mult;
        logic [RES_W-1:0]  res;
    } wd_cfg_t;
endpackage

// File: rtl/wdt_kick_sync.sv
module wdt_kick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_i,
    output logic edge_o
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } ks_state_t;

    ks_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.sync[0] = kick_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.sync[i] = st_q.sync[i-1];
        end
        st_d.prev    = st_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign edge_o = st_q.sync[STAGES-1] ^ st_q.prev;

    // R4
    edge_follows_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o || (st_q.sync[STAGES-1] != $past(st_q.sync[STAGES-1])));
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int TICK_UNIT = 4,
    parameter int RES_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [RES_W-1:0] res_i,
    output logic             tick_o
);
    localparam int MAX_SHIFT = 2 * ((1 << RES_W) - 1);
    localparam int PW        = $clog2(TICK_UNIT << MAX_SHIFT) + 1;

    typedef struct packed {
        logic [PW-1:0] cnt;
    } ps_state_t;

    ps_state_t st_d, st_q;
    logic [PW-1:0] limit;

    always_comb begin
        limit = PW'((TICK_UNIT << (2 * int'(res_i))) - 1);
    end

    assign tick_o = !clear_i && (st_q.cnt == limit);

    always_comb begin
        st_d = st_q;
        if (clear_i || tick_o) st_d.cnt = '0;
        else                   st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |-> st_q.cnt <= limit);
endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
    parameter int MULT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              tick_i,
    input  logic [MULT_W-1:0] mult_i,
    output logic              expire_o
);
    typedef struct packed {
        logic [MULT_W-1:0] cnt;
    } tc_state_t;

    tc_state_t st_d, st_q;
    logic [MULT_W-1:0] last;

    assign last     = mult_i - 1'b1;
    assign expire_o = !clear_i && tick_i && (mult_i != '0) && (st_q.cnt == last);

    always_comb begin
        st_d = st_q;
        if (clear_i || expire_o) st_d.cnt = '0;
        else if (tick_i)         st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && mult_i != '0) |-> st_q.cnt < mult_i);
endmodule

// File: rtl/wdt_edge_top.sv
module wdt_edge_top
    import wdt_edge_pkg::*;
#(
    parameter int TICK_UNIT   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_down,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             kick,
    output logic [CFG_W-1:0] cfg_o,
    output logic             timeout_o,
    output logic             irq_o,
    output logic             rst_pulse_o
);
    typedef struct packed {
        wd_cfg_t cfg;
        logic    timeout;
        logic    pulse;
    } top_state_t;

    top_state_t st_d, st_q;

    logic kick_edge, accept_wr, zero_wr, restart, run, cnt_clear, tick, expire;

    wdt_kick_sync #(.STAGES(SYNC_STAGES)) kick_sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .kick_i (kick),
        .edge_o (kick_edge)
    );

    assign accept_wr = wr_en && !pwr_down;
    assign zero_wr   = accept_wr && (wr_data == '0);
    assign restart   = accept_wr || kick_edge;
    assign run       = (st_q.cfg.mult != '0) && !pwr_down && !st_q.timeout;
    assign cnt_clear = restart || !run;

    wdt_prescaler #(.TICK_UNIT(TICK_UNIT), .RES_W(RES_W)) prescaler_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (cnt_clear),
        .res_i   (st_q.cfg.res),
        .tick_o  (tick)
    );

    wdt_tick_counter #(.MULT_W(MULT_W)) tick_counter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (cnt_clear),
        .tick_i   (tick),
        .mult_i   (st_q.cfg.mult),
        .expire_o (expire)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (pwr_down) begin
            st_d.cfg     = '0;
            st_d.timeout = 1'b0;
        end else begin
            if (accept_wr) st_d.cfg = wd_cfg_t'(wr_data);
            if (zero_wr) begin
                st_d.timeout = 1'b0;
            end else if (expire) begin
                st_d.timeout = 1'b1;
                st_d.pulse   = st_q.cfg.steer;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o       = st_q.cfg;
    assign timeout_o   = st_q.timeout;
    assign irq_o       = st_q.timeout && !st_q.cfg.steer;
    assign rst_pulse_o = st_q.pulse;

    // R8
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse_o |=> !rst_pulse_o);
    // R8
    pulse_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse_o |-> (timeout_o && cfg_o[CFG_W-1] && !irq_o));
    // R5
    timeout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_o && !pwr_down && !(wr_en && wr_data == '0)) |=> timeout_o);
    // R9
    pwrdn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (cfg_o == '0 && !timeout_o));
    // R7
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_o[CFG_W-2:RES_W] == '0) |=> !$rose(timeout_o));
endmodule

// File: tb/wdt_edge_top_tb_top.sv
module wdt_edge_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int UNIT       = 2;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_down = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       kick = 1'b0;
    logic [7:0] cfg_o;
    logic       timeout_o, irq_o, rst_pulse_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_edge_top #(.TICK_UNIT(UNIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .wr_en(wr_en),
        .wr_data(wr_data), .kick(kick), .cfg_o(cfg_o), .timeout_o(timeout_o),
        .irq_o(irq_o), .rst_pulse_o(rst_pulse_o)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // counts edges until timeout_o is seen high at a negedge; -1 if not within lim
    task automatic wait_to(input int lim, output int k);
        k = -1;
        for (int i = 1; i <= lim; i++) begin
            @(negedge clk);
            if (timeout_o) begin k = i; break; end
        end
    endtask

    function automatic int per(input int s);
        return UNIT * (4 ** s);
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, WATCHDOG);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int k, n;
        int mults[5] = '{1, 2, 3, 7, 31};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cfg_o == 8'h00, "R1", cfg_o, 0);
        chk(!timeout_o && !irq_o && !rst_pulse_o, "R1", timeout_o, 0);

        // R2 / R8 / R10 sweep
        for (int st = 0; st < 2; st++) begin
            for (int s = 0; s < 4; s++) begin
                foreach (mults[mi]) begin
                    logic [7:0] v;
                    v = {st[0], mults[mi][4:0], s[1:0]};
                    n = mults[mi] * per(s);
                    wr(v);
                    chk(cfg_o == v, "R10", cfg_o, v);
                    wait_to(n + 5, k);
                    chk(k == n, "R2", k, n);
                    chk(rst_pulse_o == st[0], "R8", rst_pulse_o, st);
                    chk(irq_o == !st[0], "R8", irq_o, !st[0]);
                    @(negedge clk);
                    chk(!rst_pulse_o && timeout_o, "R8", rst_pulse_o, 0);
                    wr(8'h00);
                    chk(!timeout_o && !irq_o, "R6", timeout_o, 0);
                end
            end
        end

        // R3 rewrite with same value restarts
        wr({1'b0, 5'd4, 2'd1});           // N = 4*8 = 32
        repeat (20) @(negedge clk);
        chk(!timeout_o, "R3", timeout_o, 0);
        wr({1'b0, 5'd4, 2'd1});
        wait_to(50, k);
        chk(k == 32, "R3", k, 32);
        wr(8'h00);

        // R4 rising kick
        wr({1'b0, 5'd4, 2'd0});           // N = 8
        repeat (2) @(negedge clk);
        kick = 1'b1;
        wait_to(30, k);
        chk(k == 8 + 3, "R4", k, 11);
        wr(8'h00);
        // R4 falling kick
        wr({1'b0, 5'd4, 2'd0});
        repeat (2) @(negedge clk);
        kick = 1'b0;
        wait_to(30, k);
        chk(k == 8 + 3, "R4", k, 11);

        // R5 sticky through nonzero write and kick
        wr({1'b1, 5'd1, 2'd0});
        kick = 1'b1;
        repeat (40) @(negedge clk);
        chk(timeout_o, "R5", timeout_o, 1);
        chk(!rst_pulse_o, "R5", rst_pulse_o, 0);
        wr(8'h00);
        chk(!timeout_o, "R6", timeout_o, 0);

        // R6 disabled by zero
        repeat (300) @(negedge clk);
        chk(!timeout_o, "R6", timeout_o, 0);

        // R7 zero multiplier with nonzero select
        for (int s = 1; s < 4; s++) begin
            wr({1'b0, 5'd0, s[1:0]});
            wait_to(400, k);
            chk(k == -1, "R7", k, -1);
        end

        // R9 power-down mid-count, with pending timeout, and write ignored
        wr({1'b0, 5'd3, 2'd1});           // N = 24
        repeat (10) @(negedge clk);
        pwr_down = 1'b1;
        @(negedge clk);
        chk(cfg_o == 8'h00, "R9", cfg_o, 0);
        wr_en = 1'b1; wr_data = 8'h05;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        chk(cfg_o == 8'h00, "R9", cfg_o, 0);
        pwr_down = 1'b0;
        wait_to(100, k);
        chk(k == -1, "R9", k, -1);
        wr({1'b0, 5'd1, 2'd0});
        wait_to(10, k);
        chk(timeout_o && irq_o, "R9", timeout_o, 1);
        pwr_down = 1'b1;
        @(negedge clk);
        chk(!timeout_o && !irq_o && cfg_o == 0, "R9", timeout_o, 0);
        pwr_down = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule